// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting timer/counters, timer 0 and timer 1. Each one advances either once per machine cycle or once per falling edge seen on its own count pin. A machine cycle is `MC_DIV` clocks, 12 by default. Software sets up and reads the block through a byte-wide register port. That port gives access to a mode byte, a control byte and the four count bytes. Each timer has its own overflow flag, and the flag drives an interrupt request. The interrupt controller clears a flag through a one-cycle acknowledge input.

Each timer takes a 4-bit configuration nibble. The nibble holds a gate bit, a clock-source select and a 2-bit mode. The four modes are:

- mode 0: a 13-bit counter with a 5-bit prescaler in the low byte.
- mode 1: a full 16-bit counter.
- mode 2: an 8-bit counter that reloads itself from the high byte.
- mode 3: split mode.

When timer 0 is in split mode it becomes two 8-bit counters. Its high half takes over timer 1's run bit and timer 1's overflow flag. Timer 1 then counts whenever it is not in its own mode 3, and it raises no flag.

A software write to any count byte of a timer takes priority over that timer's count in the same cycle.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow flags are low. Register addresses:
  - 0: mode
  - 1: control
  - 2: timer 0 low
  - 3: timer 0 high
  - 4: timer 1 low
  - 5: timer 1 high

  Addresses 6 and 7 read 0x00 and ignore writes.
- R2: In timer function, an enabled timer advances by exactly one per machine cycle (`MC_DIV` clocks). A stopped timer keeps its count.
- R3: A timer counts only when its run bit is 1 and either its gate bit is 0 or its gate pin is 1. In the control byte, bit 0 is run 0 and bit 1 is run 1. In the mode byte, timer 0 uses bits 3:0 and timer 1 uses bits 7:4. Within a nibble, bit 3 is the gate, bit 2 selects the count pin, and bits 1:0 are the mode.
- R4: In counter function (nibble bit 2 = 1), the count pin is sampled once per machine cycle. The timer advances once for each high sample that is followed by a low sample, one machine cycle after the detection.
- R5: Mode 1 counts through 16 bits. The wrap from 0xFFFF to 0x0000 sets the flag, and counting continues.
- R6: Mode 0 counts the 13-bit value {high byte, low byte bits 4:0}. Low-byte bits 7:5 are left unchanged, and the wrap to zero sets the flag.
- R7: In mode 2 the low byte counts. On its overflow the low byte is loaded from the high byte and the flag is set. The high byte never changes through counting.
- R8: Timer 1 in mode 3 keeps its count whatever its run bit is.
- R9: With timer 0 in mode 3, each half counts on its own:
  - The low byte counts under timer 0's run, gate and source, and sets flag 0.
  - The high byte counts machine cycles under run 1, and sets flag 1.
- R10: While timer 0 is in mode 3, timer 1 counts machine cycles even with run 1 at 0, unless it is in its own mode 3. Its overflow does not set flag 1.
- R11: Control bits 2 and 3 are flags 0 and 1, and they appear on `ovf_flag`. Priority, from highest to lowest:
  - an overflow sets the flag;
  - a pulse on `flag_clr[i]` clears it;
  - a software write of the control byte loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| cnt_pin | input | 2 | External count inputs, index = timer |
| gate_pin | input | 2 | External gate inputs, index = timer |
| flag_clr | input | 2 | Hardware flag clear from interrupt acknowledge |
| ovf_flag | output | 2 | Overflow flags, index = flag number |

## Verification
Timer function runs with the gate pin held low and then high over equal windows. This separates the run/gate qualification from the machine-cycle count rate. Each mode starts a few counts below its wrap point. The final value then distinguishes 13-bit, 16-bit, reload and split arithmetic, including the untouched upper low-byte bits and the unchanged reload byte. Counter function is fed slow pulses on the pin, so only true falling edges add counts. The split-mode runs show flag 1 being driven by the upper half of timer 0, and timer 1 running free of its run bit without raising a flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_TMR  = 2;

  typedef enum logic [1:0] {
    TM_13     = 2'd0,
    TM_16     = 2'd1,
    TM_RELOAD = 2'd2,
    TM_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0L  = 3'd2;
  localparam logic [ADDR_W-1:0] A_T0H  = 3'd3;
  localparam logic [ADDR_W-1:0] A_T1L  = 3'd4;
  localparam logic [ADDR_W-1:0] A_T1H  = 3'd5;

  localparam int unsigned RUN_LSB  = 0;
  localparam int unsigned FLAG_LSB = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp_q, smp_d;
  logic old_q, old_d;

  always_comb begin
    smp_d = tick ? pin   : smp_q;
    old_d = tick ? smp_q : old_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      old_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      old_q <= old_d;
    end
  end

  // high sample followed by low sample; held for the next machine cycle
  assign fall = old_q & ~smp_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned W   = BYTE_W,
  parameter int unsigned PRE = 5
) (
  input  tmr_mode_e    mode,
  input  logic         en_lo,
  input  logic         en_hi,
  input  logic [W-1:0] lo_q,
  input  logic [W-1:0] hi_q,
  output logic [W-1:0] lo_d,
  output logic [W-1:0] hi_d,
  output logic         ovf_main,
  output logic         ovf_upper
);
  localparam int unsigned W13 = W + PRE;

  logic [W13-1:0] c13, n13;
  logic [2*W-1:0] c16, n16;

  assign c13 = {hi_q, lo_q[PRE-1:0]};
  assign n13 = c13 + W13'(1);
  assign c16 = {hi_q, lo_q};
  assign n16 = c16 + (2*W)'(1);

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    ovf_main  = 1'b0;
    ovf_upper = 1'b0;
    unique case (mode)
      TM_13: if (en_lo) begin
        hi_d     = n13[W13-1:PRE];
        lo_d     = {lo_q[W-1:PRE], n13[PRE-1:0]};
        ovf_main = &c13;
      end
      TM_16: if (en_lo) begin
        {hi_d, lo_d} = n16;
        ovf_main     = &c16;
      end
      TM_RELOAD: if (en_lo) begin
        if (&lo_q) begin
          lo_d     = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_d = lo_q + W'(1);
        end
      end
      TM_SPLIT: begin
        if (en_lo) begin
          lo_d     = lo_q + W'(1);
          ovf_main = &lo_q;
        end
        if (en_hi) begin
          hi_d      = hi_q + W'(1);
          ovf_upper = &hi_q;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned MC_DIV = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  input  logic [N_TMR-1:0]    cnt_pin,
  input  logic [N_TMR-1:0]    gate_pin,
  input  logic [N_TMR-1:0]    flag_clr,
  output logic [N_TMR-1:0]    ovf_flag
);
  localparam int unsigned NIB = BYTE_W / 2;

  logic                          mc_tick;
  logic [BYTE_W-1:0]             mode_q, mode_d;
  logic [N_TMR-1:0]              run_q, run_d;
  logic [N_TMR-1:0]              flag_q, flag_d;
  logic [N_TMR-1:0][BYTE_W-1:0]  lo_q, lo_d, hi_q, hi_d;
  logic [N_TMR-1:0][BYTE_W-1:0]  core_lo, core_hi;
  logic [N_TMR-1:0]              fall, src_ok, gate_ok, wr_lo, wr_hi, wr_any;
  logic [N_TMR-1:0]              en_lo, en_hi, ovf_main, ovf_upper, flag_set;
  tmr_cfg_t [N_TMR-1:0]          cfg;
  logic                          wr_mode, wr_ctrl, split0;

  tmr_prescale #(.DIV(MC_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (mc_tick)
  );

  assign wr_mode = reg_wr & (reg_addr == A_MODE);
  assign wr_ctrl = reg_wr & (reg_addr == A_CTRL);

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign cfg[i]     = tmr_cfg_t'(mode_q[i*NIB +: NIB]);
    assign wr_lo[i]   = reg_wr & (reg_addr == (A_T0L + ADDR_W'(2*i)));
    assign wr_hi[i]   = reg_wr & (reg_addr == (A_T0H + ADDR_W'(2*i)));
    assign wr_any[i]  = wr_lo[i] | wr_hi[i];
    assign src_ok[i]  = cfg[i].ext_src ? fall[i] : 1'b1;
    assign gate_ok[i] = ~cfg[i].gate | gate_pin[i];

    tmr_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (mc_tick),
      .pin  (cnt_pin[i]),
      .fall (fall[i])
    );

    tmr_core #(.W(BYTE_W)) u_core (
      .mode     (cfg[i].mode),
      .en_lo    (en_lo[i]),
      .en_hi    (en_hi[i]),
      .lo_q     (lo_q[i]),
      .hi_q     (hi_q[i]),
      .lo_d     (core_lo[i]),
      .hi_d     (core_hi[i]),
      .ovf_main (ovf_main[i]),
      .ovf_upper(ovf_upper[i])
    );
  end

  assign split0 = (cfg[0].mode == TM_SPLIT);

  // timer 0: low/full counter on its own controls, upper half (split) on run 1
  assign en_lo[0] = mc_tick & src_ok[0] & gate_ok[0] & run_q[0] & ~wr_any[0];
  assign en_hi[0] = mc_tick & run_q[1] & ~wr_any[0];
  // timer 1: loses its run bit to timer 0 in split, halts in its own mode 3
  assign en_lo[1] = mc_tick & src_ok[1] & gate_ok[1] & (split0 | run_q[1])
                  & ~wr_any[1] & (cfg[1].mode != TM_SPLIT);
  assign en_hi[1] = 1'b0;

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split0 ? ovf_upper[0] : ovf_main[1];

  always_comb begin
    mode_d = wr_mode ? reg_wdata : mode_q;
    run_d  = wr_ctrl ? reg_wdata[RUN_LSB +: N_TMR] : run_q;
    for (int i = 0; i < N_TMR; i++) begin
      flag_d[i] = flag_set[i]
                | (~flag_clr[i] & (wr_ctrl ? reg_wdata[FLAG_LSB + i] : flag_q[i]));
      lo_d[i]   = wr_lo[i] ? reg_wdata : core_lo[i];
      hi_d[i]   = wr_hi[i] ? reg_wdata : core_hi[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = BYTE_W'({flag_q, run_q});
      A_T0L:   reg_rdata = lo_q[0];
      A_T0H:   reg_rdata = hi_q[0];
      A_T1L:   reg_rdata = lo_q[1];
      A_T1H:   reg_rdata = hi_q[1];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         mc_tick,
  input logic                         reg_wr,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [BYTE_W-1:0]            mode_q,
  input logic [N_TMR-1:0][BYTE_W-1:0] lo_q,
  input logic [N_TMR-1:0][BYTE_W-1:0] hi_q,
  input logic [N_TMR-1:0]             ovf_flag
);
  logic wr_t0l, wr_t0h, wr_t1, wr_ctl;
  assign wr_t0l = reg_wr && (reg_addr == A_T0L);
  assign wr_t0h = reg_wr && (reg_addr == A_T0H);
  assign wr_t1  = reg_wr && ((reg_addr == A_T1L) || (reg_addr == A_T1H));
  assign wr_ctl = reg_wr && (reg_addr == A_CTRL);

  // R2
  cnt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_tick && !reg_wr) |=> ($stable(lo_q) && $stable(hi_q)));

  // R6
  lo_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0 && !wr_t0l) |=> $stable(lo_q[0][7:5]));

  // R7
  reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd2 && !wr_t0h) |=> $stable(hi_q[0]));

  // R8
  t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'd3 && !wr_t1) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

  // R11
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_tick && !wr_ctl && ovf_flag == 2'b00) |=> (ovf_flag == 2'b00));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mc_tick (mc_tick),
  .reg_wr  (reg_wr),
  .reg_addr(reg_addr),
  .mode_q  (mode_q),
  .lo_q    (lo_q),
  .hi_q    (hi_q),
  .ovf_flag(ovf_flag)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_pin, gate_pin, flag_clr, ovf_flag;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  probe  = 1'b0;
  bit  done   = 1'b0;

  typedef struct {
    logic [2:0] addr;
    bit         pins;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  tmr_pair #(.MC_DIV(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .flag_clr(flag_clr), .ovf_flag(ovf_flag)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (probe && sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.pins ? {6'b0, ovf_flag} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d act=%02h exp=%02h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.pins = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    reg_addr = a; probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic chk_pins(input logic [1:0] e, input string tag);
    item_t it;
    it.addr = 3'd7; it.pins = 1'b1; it.exp = {6'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    reg_addr = 3'd7; probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    flag_clr = m;
    @(posedge clk); #1;
    flag_clr = 2'b00;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    cnt_pin = '0; gate_pin = '0; flag_clr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_edges(1);

    // R1: reset state of every register and flag
    for (int a = 0; a < 8; a++) chk_reg(3'(a), 8'h00, "R1 reset read");
    chk_pins(2'b00, "R1 reset flags");
    wr_reg(3'd6, 8'hFF);
    chk_reg(3'd6, 8'h00, "R1 unused address");

    // R3 / R2: gated timer 0, 16-bit, gate pin low then high
    wr_reg(3'd0, 8'h09);
    gate_pin[0] = 1'b0;
    wr_reg(3'd1, 8'h01);
    wait_edges(119);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd2, 8'h00, "R3 gate pin low blocks count");
    gate_pin[0] = 1'b1;
    wr_reg(3'd1, 8'h01);
    wait_edges(119);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd2, 8'h0A, "R2 one count per machine cycle");
    chk_reg(3'd3, 8'h00, "R2 high byte");
    gate_pin[0] = 1'b0;

    // R5: 16-bit wrap
    wr_reg(3'd0, 8'h01);
    wr_reg(3'd2, 8'hFE);
    wr_reg(3'd3, 8'hFF);
    wr_reg(3'd1, 8'h01);
    wait_edges(24);
    chk_pins(2'b01, "R5 wrap sets flag 0");
    wait_edges(10);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd2, 8'h01, "R5 low after wrap");
    chk_reg(3'd3, 8'h00, "R5 high after wrap");

    // R6: 13-bit with prescaler low bits
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd2, 8'hFE);
    wr_reg(3'd3, 8'hFF);
    wr_reg(3'd1, 8'h01);
    wait_edges(24);
    chk_pins(2'b01, "R6 13-bit wrap sets flag 0");
    wait_edges(10);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd2, 8'hE1, "R6 low keeps bits 7:5");
    chk_reg(3'd3, 8'h00, "R6 high after wrap");

    // R7 / R11: timer 1 auto-reload, then hardware clear
    wr_reg(3'd0, 8'h20);
    wr_reg(3'd4, 8'hFE);
    wr_reg(3'd5, 8'hF0);
    wr_reg(3'd1, 8'h02);
    wait_edges(24);
    chk_pins(2'b10, "R7 reload sets flag 1");
    pulse_clr(2'b10);
    chk_pins(2'b00, "R11 acknowledge clears flag 1");
    wait_edges(8);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd4, 8'hF1, "R7 low reloaded then counted");
    chk_reg(3'd5, 8'hF0, "R7 high unchanged");

    // R11: software set and clear, acknowledge beats write
    wr_reg(3'd1, 8'h04);
    chk_pins(2'b01, "R11 software sets flag 0");
    chk_reg(3'd1, 8'h04, "R11 control readback");
    wr_reg(3'd1, 8'h00);
    chk_pins(2'b00, "R11 software clears flag 0");
    reg_addr = 3'd1; reg_wdata = 8'h08; reg_wr = 1'b1; flag_clr = 2'b10;
    @(posedge clk); #1;
    reg_wr = 1'b0; flag_clr = 2'b00;
    chk_pins(2'b00, "R11 acknowledge wins over write");

    // R4: counter function on timer 1
    wr_reg(3'd0, 8'h50);
    wr_reg(3'd4, 8'h00);
    wr_reg(3'd5, 8'h00);
    cnt_pin[1] = 1'b1;
    wait_edges(48);
    wr_reg(3'd1, 8'h02);
    for (int k = 0; k < 5; k++) begin
      cnt_pin[1] = 1'b0; wait_edges(24);
      cnt_pin[1] = 1'b1; wait_edges(24);
    end
    wait_edges(48);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd4, 8'h05, "R4 one count per falling edge");
    chk_reg(3'd5, 8'h00, "R4 high byte");

    // R9 / R8: timer 0 split, timer 1 in mode 3
    wr_reg(3'd0, 8'h33);
    wr_reg(3'd2, 8'hFF);
    wr_reg(3'd3, 8'hFF);
    wr_reg(3'd4, 8'h55);
    wr_reg(3'd5, 8'hAA);
    wr_reg(3'd1, 8'h03);
    wait_edges(23);
    chk_pins(2'b11, "R9 both halves raise flags");
    wait_edges(11);
    wr_reg(3'd1, 8'h00);
    chk_reg(3'd2, 8'h02, "R9 low half count");
    chk_reg(3'd3, 8'h02, "R9 high half count");
    chk_reg(3'd4, 8'h55, "R8 timer 1 low held");
    chk_reg(3'd5, 8'hAA, "R8 timer 1 high held");

    // R10: timer 1 runs without its run bit and raises no flag
    wr_reg(3'd4, 8'hFF);
    wr_reg(3'd5, 8'hFF);
    wr_reg(3'd0, 8'h13);
    wait_edges(35);
    wr_reg(3'd0, 8'h33);
    chk_reg(3'd4, 8'h02, "R10 timer 1 low counted");
    chk_reg(3'd5, 8'h00, "R10 timer 1 high wrapped");
    chk_pins(2'b00, "R10 no flag from timer 1");
    chk_reg(3'd2, 8'h02, "R9 halves idle without run");

    wait_edges(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule